// File: doc/BRIEF.md
# Bridge Address Window Decoder

This block sits beside the configuration space of a PCI-to-PCI bridge and decides, for each transaction seen on the primary side, whether the bridge should claim it and pass it to the secondary side. It takes the packed base and limit register values for the I/O window, the non-prefetchable memory window and the prefetchable memory window. It rebuilds each window's full byte-address span from the packed fields. It then checks the transaction address against every window that the command-register enables have switched on.

The bridge-control legacy-display enable adds three fixed ranges to the decision: one memory range and two I/O ranges. Each request is presented with a one-cycle strobe. One clock later the block returns a registered forward flag and a code naming the window that claimed the address. Register storage, bus handshakes and completions belong to the surrounding logic.

Top module: `brwin_decoder`

## Requirements
- R1: A request strobed on `req_valid` at a rising edge produces `rsp_valid` high for exactly the following cycle, with `rsp_forward` and `rsp_window` updated at that same edge. Both outputs hold their values while no request is strobed. After reset, `rsp_valid`, `rsp_forward` and `rsp_window` are all zero.
- R2: I/O window in 16-bit mode: base = `io_base_reg[7:4]` << 12. Limit = (`io_limit_reg[7:4]` << 12) with bits 11:0 forced to ones.
- R3: An I/O register whose low nibble equals 4'h1 is 32-bit. Its upper register (`io_base_up` or `io_limit_up`) then supplies address bits 31:16. When `io_base_reg` is not 32-bit, I/O requests are compared on `req_addr[15:0]` only. When it is 32-bit, they are compared on `req_addr[31:0]`.
- R4: Memory window: base = `mem_base_reg[15:4]` << 20. Limit = (`mem_limit_reg[15:4]` << 20) with bits 19:0 forced to ones. Memory requests are compared on all 64 address bits.
- R5: Prefetchable window: built like R4 from `pf_base_reg` and `pf_limit_reg`. A register whose low nibble equals 4'h1 is 64-bit, and its upper register (`pf_base_up` or `pf_limit_up`) then supplies bits 63:32. Otherwise bits 63:32 are zero.
- R6: The I/O window matches only I/O requests (`req_is_io`=1) and only while `cmd_io_en` is set. The memory and prefetchable windows match only memory requests and only while `cmd_mem_en` is set.
- R7: A window whose rebuilt limit is below its rebuilt base never matches.
- R8: While `vga_en` is set, memory requests to 0xA0000..0xBFFFF and I/O requests to 0x3B0..0x3BB or 0x3C0..0x3DF are forwarded, whatever the command enables.
- R9: `rsp_window` codes are 0 none, 1 I/O, 2 memory, 3 prefetchable, 4 legacy display. On a multiple hit the priority is prefetchable over memory over legacy display, and I/O over legacy display.
- R10: Window matches include both ends: an address equal to the base or to the limit matches.
- R11: `rsp_forward` is 1 exactly when `rsp_window` is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_is_io | input | 1 | 1 = I/O space request, 0 = memory space request |
| req_addr | input | 64 | Request byte address |
| io_base_reg | input | 8 | Packed I/O base register |
| io_limit_reg | input | 8 | Packed I/O limit register |
| io_base_up | input | 16 | I/O base bits 31:16 |
| io_limit_up | input | 16 | I/O limit bits 31:16 |
| mem_base_reg | input | 16 | Packed memory base register |
| mem_limit_reg | input | 16 | Packed memory limit register |
| pf_base_reg | input | 16 | Packed prefetchable base register |
| pf_limit_reg | input | 16 | Packed prefetchable limit register |
| pf_base_up | input | 32 | Prefetchable base bits 63:32 |
| pf_limit_up | input | 32 | Prefetchable limit bits 63:32 |
| cmd_io_en | input | 1 | Command register I/O space enable |
| cmd_mem_en | input | 1 | Command register memory space enable |
| vga_en | input | 1 | Bridge control legacy display enable |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_forward | output | 1 | Forward the request to the secondary side |
| rsp_window | output | 3 | Window that matched (see R9) |

## Verification
Each window is probed at its base, at its padded limit and one byte outside each end. This separates a correct inclusive compare and limit padding from off-by-one and missing-fill faults. Each window is also probed in its narrow and wide type modes, with non-zero upper registers, to show whether the type code gates the upper bits. It is also probed with its enable cleared, with a request of the other space type, and with the limit below the base. Overlapping prefetchable, memory and legacy-display ranges separate the priority order from the plain forward decision.

// File: rtl/brwin_pkg.sv
// Shared types and constants for the bridge address window decoder.
// Assumes 64-bit byte addresses on the primary side.
package brwin_pkg;

    localparam int ADDR_W      = 64;
    localparam int IO_GRAN_W   = 12;   // I/O limit fill width (4 KiB)
    localparam int MEM_GRAN_W  = 20;   // memory limit fill width (1 MiB)
    localparam int VGA_SPANS   = 3;    // one memory and two I/O legacy ranges

    typedef enum logic [2:0] {
        WIN_NONE = 3'd0,
        WIN_IO   = 3'd1,
        WIN_MEM  = 3'd2,
        WIN_PREF = 3'd3,
        WIN_VGA  = 3'd4
    } brwin_sel_e;

    typedef enum logic [1:0] {
        KIND_IO   = 2'd0,
        KIND_MEM  = 2'd1,
        KIND_PREF = 2'd2
    } brwin_kind_e;

    typedef struct packed {
        logic [ADDR_W-1:0] lo;
        logic [ADDR_W-1:0] hi;
    } brwin_span_t;

    // Fixed legacy display ranges: index 0 memory, 1 and 2 I/O.
    function automatic brwin_span_t vga_span(input int idx);
        brwin_span_t s;
        case (idx)
            0:       begin s.lo = 64'h000A_0000; s.hi = 64'h000B_FFFF; end
            1:       begin s.lo = 64'h0000_03B0; s.hi = 64'h0000_03BB; end
            default: begin s.lo = 64'h0000_03C0; s.hi = 64'h0000_03DF; end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/brwin_span_build.sv
// Rebuilds one bridge window's full base and limit from its packed
// register fields. KIND selects the I/O, memory or prefetchable layout.
// Assumes a type nibble of 4'h1 marks the wide (32/64-bit) form.
module brwin_span_build
    import brwin_pkg::*;
#(
    parameter brwin_kind_e KIND = KIND_MEM
) (
    input  logic [15:0]   base_reg,
    input  logic [15:0]   limit_reg,
    input  logic [31:0]   base_up,
    input  logic [31:0]   limit_up,
    output brwin_span_t   span,
    output logic          base_wide
);

    localparam logic [3:0] WIDE_CODE = 4'h1;

    logic limit_wide;

    // Decode the type nibble of each register.
    always_comb begin
        base_wide  = (base_reg[3:0]  == WIDE_CODE);
        limit_wide = (limit_reg[3:0] == WIDE_CODE);
    end

    generate
        if (KIND == KIND_IO) begin : g_io
            logic unused_io;
            assign unused_io = ^{base_reg[15:8], limit_reg[15:8],
                                 base_up[31:16], limit_up[31:16]};
            // Assemble the I/O span with 4 KiB limit fill.
            always_comb begin
                span.lo = '0;
                span.hi = '0;
                span.lo[15:IO_GRAN_W] = base_reg[7:4];
                span.hi[15:IO_GRAN_W] = limit_reg[7:4];
                span.hi[IO_GRAN_W-1:0] = '1;
                if (base_wide)  span.lo[31:16] = base_up[15:0];
                if (limit_wide) span.hi[31:16] = limit_up[15:0];
            end
        end else if (KIND == KIND_MEM) begin : g_mem
            logic unused_mem;
            assign unused_mem = ^{base_up, limit_up, base_wide, limit_wide};
            // Assemble the 32-bit memory span with 1 MiB limit fill.
            always_comb begin
                span.lo = '0;
                span.hi = '0;
                span.lo[31:MEM_GRAN_W] = base_reg[15:4];
                span.hi[31:MEM_GRAN_W] = limit_reg[15:4];
                span.hi[MEM_GRAN_W-1:0] = '1;
            end
        end else begin : g_pref
            // Assemble the prefetchable span, wide when the type says so.
            always_comb begin
                span.lo = '0;
                span.hi = '0;
                span.lo[31:MEM_GRAN_W] = base_reg[15:4];
                span.hi[31:MEM_GRAN_W] = limit_reg[15:4];
                span.hi[MEM_GRAN_W-1:0] = '1;
                if (base_wide)  span.lo[ADDR_W-1:32] = base_up;
                if (limit_wide) span.hi[ADDR_W-1:32] = limit_up;
            end
        end
    endgenerate

endmodule

// File: rtl/brwin_span_match.sv
// Inclusive range test of an address against one span.
// Assumes an inverted span (limit below base) must never match.
module brwin_span_match
    import brwin_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  brwin_span_t       span,
    input  logic              enable,
    output logic              hit
);

    logic non_empty;
    logic above_lo;
    logic below_hi;

    // Compare both ends inclusively and gate with the enable.
    always_comb begin
        non_empty = (span.lo <= span.hi);
        above_lo  = (addr >= span.lo);
        below_hi  = (addr <= span.hi);
        hit       = enable & non_empty & above_lo & below_hi;
    end

endmodule

// File: rtl/brwin_decoder.sv
// Top of the bridge address window decoder. Rebuilds the three bridge
// windows, tests the request address against them and the legacy display
// ranges, picks the reporting window by priority and registers the result.
// Assumes config inputs are stable while a request is strobed.
module brwin_decoder
    import brwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_is_io,
    input  logic [63:0]       req_addr,
    input  logic [7:0]        io_base_reg,
    input  logic [7:0]        io_limit_reg,
    input  logic [15:0]       io_base_up,
    input  logic [15:0]       io_limit_up,
    input  logic [15:0]       mem_base_reg,
    input  logic [15:0]       mem_limit_reg,
    input  logic [15:0]       pf_base_reg,
    input  logic [15:0]       pf_limit_reg,
    input  logic [31:0]       pf_base_up,
    input  logic [31:0]       pf_limit_up,
    input  logic              cmd_io_en,
    input  logic              cmd_mem_en,
    input  logic              vga_en,
    output logic              rsp_valid,
    output logic              rsp_forward,
    output logic [2:0]        rsp_window
);

    brwin_span_t       io_span, mem_span, pf_span;
    logic              io_wide, mem_wide_unused, pf_wide_unused;
    logic [ADDR_W-1:0] io_addr;
    logic              io_hit, mem_hit, pf_hit;
    logic [VGA_SPANS-1:0] vga_hit;
    brwin_sel_e        pick;
    logic              fwd_next;

    brwin_span_build #(.KIND(KIND_IO)) u_io_build (
        .base_reg  ({8'h00, io_base_reg}),
        .limit_reg ({8'h00, io_limit_reg}),
        .base_up   ({16'h0000, io_base_up}),
        .limit_up  ({16'h0000, io_limit_up}),
        .span      (io_span),
        .base_wide (io_wide)
    );

    brwin_span_build #(.KIND(KIND_MEM)) u_mem_build (
        .base_reg  (mem_base_reg),
        .limit_reg (mem_limit_reg),
        .base_up   (32'h0),
        .limit_up  (32'h0),
        .span      (mem_span),
        .base_wide (mem_wide_unused)
    );

    brwin_span_build #(.KIND(KIND_PREF)) u_pf_build (
        .base_reg  (pf_base_reg),
        .limit_reg (pf_limit_reg),
        .base_up   (pf_base_up),
        .limit_up  (pf_limit_up),
        .span      (pf_span),
        .base_wide (pf_wide_unused)
    );

    // Narrow the I/O address view to 16 or 32 bits per the base type.
    always_comb begin
        io_addr = '0;
        if (io_wide) io_addr[31:0] = req_addr[31:0];
        else         io_addr[15:0] = req_addr[15:0];
    end

    brwin_span_match u_io_match (
        .addr   (io_addr),
        .span   (io_span),
        .enable (cmd_io_en & req_is_io),
        .hit    (io_hit)
    );

    brwin_span_match u_mem_match (
        .addr   (req_addr),
        .span   (mem_span),
        .enable (cmd_mem_en & ~req_is_io),
        .hit    (mem_hit)
    );

    brwin_span_match u_pf_match (
        .addr   (req_addr),
        .span   (pf_span),
        .enable (cmd_mem_en & ~req_is_io),
        .hit    (pf_hit)
    );

    generate
        for (genvar g = 0; g < VGA_SPANS; g++) begin : g_vga
            localparam bit IS_MEM = (g == 0);
            brwin_span_match u_vga_match (
                .addr   (IS_MEM ? req_addr : io_addr),
                .span   (vga_span(g)),
                .enable (vga_en & (IS_MEM ? ~req_is_io : req_is_io)),
                .hit    (vga_hit[g])
            );
        end
    endgenerate

    // Choose the reporting window by fixed priority.
    always_comb begin
        if (pf_hit)         pick = WIN_PREF;
        else if (mem_hit)   pick = WIN_MEM;
        else if (io_hit)    pick = WIN_IO;
        else if (|vga_hit)  pick = WIN_VGA;
        else                pick = WIN_NONE;
        fwd_next = pf_hit | mem_hit | io_hit | (|vga_hit);
    end

    // Register the decision one cycle after the request strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_forward <= 1'b0;
            rsp_window  <= WIN_NONE;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_forward <= fwd_next;
                rsp_window  <= pick;
            end
        end
    end

endmodule

// File: rtl/brwin_checker.sv
// Port-level temporal checks for brwin_decoder, bound to every instance.
// Assumes synchronous active-low reset.
module brwin_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_is_io,
    input logic [63:0] req_addr,
    input logic        cmd_io_en,
    input logic        cmd_mem_en,
    input logic        vga_en,
    input logic        rsp_valid,
    input logic        rsp_forward,
    input logic [2:0]  rsp_window
);

    p_valid_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(rsp_forward) && $stable(rsp_window)));

    p_io_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_is_io && !cmd_io_en && !vga_en) |=> !rsp_forward);

    p_mem_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_io && !cmd_mem_en && !vga_en) |=> !rsp_forward);

    p_vga_io_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_is_io && vga_en && req_addr[31:0] == 32'h3C0)
        |=> rsp_forward);

    p_io_codes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_is_io)
        |=> (rsp_window == 3'd0 || rsp_window == 3'd1 || rsp_window == 3'd4));

    p_flag_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_forward == (rsp_window != 3'd0)));

endmodule

bind brwin_decoder brwin_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_is_io   (req_is_io),
    .req_addr    (req_addr),
    .cmd_io_en   (cmd_io_en),
    .cmd_mem_en  (cmd_mem_en),
    .vga_en      (vga_en),
    .rsp_valid   (rsp_valid),
    .rsp_forward (rsp_forward),
    .rsp_window  (rsp_window)
);

// File: tb/sim_brwin_decoder.sv
module sim_brwin_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_is_io = 1'b0;
    logic [63:0] req_addr = '0;
    logic [7:0]  io_base_reg = '0, io_limit_reg = '0;
    logic [15:0] io_base_up = '0, io_limit_up = '0;
    logic [15:0] mem_base_reg = '0, mem_limit_reg = '0;
    logic [15:0] pf_base_reg = '0, pf_limit_reg = '0;
    logic [31:0] pf_base_up = '0, pf_limit_up = '0;
    logic        cmd_io_en = 1'b0, cmd_mem_en = 1'b0, vga_en = 1'b0;
    logic        rsp_valid, rsp_forward;
    logic [2:0]  rsp_window;

    int n_checks = 0;
    int n_fail   = 0;

    localparam logic [2:0] W_NONE = 3'd0, W_IO = 3'd1, W_MEM = 3'd2,
                           W_PREF = 3'd3, W_VGA = 3'd4;

    always #10 clk = ~clk;   // 50 MHz

    brwin_decoder u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_io(req_is_io),
        .req_addr(req_addr), .io_base_reg(io_base_reg), .io_limit_reg(io_limit_reg),
        .io_base_up(io_base_up), .io_limit_up(io_limit_up),
        .mem_base_reg(mem_base_reg), .mem_limit_reg(mem_limit_reg),
        .pf_base_reg(pf_base_reg), .pf_limit_reg(pf_limit_reg),
        .pf_base_up(pf_base_up), .pf_limit_up(pf_limit_up),
        .cmd_io_en(cmd_io_en), .cmd_mem_en(cmd_mem_en), .vga_en(vga_en),
        .rsp_valid(rsp_valid), .rsp_forward(rsp_forward), .rsp_window(rsp_window)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input string act, input string exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %s expected %s", req, what, act, exp);
        end
    endtask

    // One request; result checked one cycle later at the falling edge.
    task automatic probe(input logic [63:0] a, input logic io, input logic ef,
                         input logic [2:0] ew, input string req);
        @(negedge clk);
        req_addr = a; req_is_io = io; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid === 1'b1 && rsp_forward === ef && rsp_window === ew, req,
              $sformatf("addr %h io %0d", a, io),
              $sformatf("v%0d f%0d w%0d", rsp_valid, rsp_forward, rsp_window),
              $sformatf("v1 f%0d w%0d", ef, ew));
    endtask

    task automatic close_all();
        io_base_reg = 8'hF0;   io_limit_reg = 8'h00;
        io_base_up = '0;       io_limit_up = '0;
        mem_base_reg = 16'hFFF0; mem_limit_reg = 16'h0000;
        pf_base_reg = 16'hFFF0;  pf_limit_reg = 16'h0000;
        pf_base_up = '0;       pf_limit_up = '0;
        cmd_io_en = 1'b0; cmd_mem_en = 1'b0; vga_en = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(rsp_valid === 1'b0 && rsp_forward === 1'b0 && rsp_window === 3'd0,
              "R1", "reset state",
              $sformatf("v%0d f%0d w%0d", rsp_valid, rsp_forward, rsp_window), "v0 f0 w0");
        rst_n = 1'b1;
    endtask

    task automatic t_hold();
        // R1: outputs hold while no request is strobed.
        probe(64'h2100, 1'b1, 1'b1, W_IO, "R1");
        req_addr = 64'h9000;
        @(negedge clk);
        check(rsp_valid === 1'b0 && rsp_forward === 1'b1 && rsp_window === W_IO,
              "R1", "hold after idle cycle",
              $sformatf("v%0d f%0d w%0d", rsp_valid, rsp_forward, rsp_window), "v0 f1 w1");
    endtask

    task automatic t_io16();
        close_all();
        io_base_reg = 8'h20; io_limit_reg = 8'h30; cmd_io_en = 1'b1;
        probe(64'h2000, 1'b1, 1'b1, W_IO,   "R10");
        probe(64'h3FFF, 1'b1, 1'b1, W_IO,   "R2");
        probe(64'h4000, 1'b1, 1'b0, W_NONE, "R2");
        probe(64'h1FFF, 1'b1, 1'b0, W_NONE, "R10");
        probe(64'h0001_2100, 1'b1, 1'b1, W_IO, "R3");
        probe(64'h2000, 1'b0, 1'b0, W_NONE, "R6");
        cmd_io_en = 1'b0;
        probe(64'h2000, 1'b1, 1'b0, W_NONE, "R6");
        cmd_io_en = 1'b1;
        t_hold();
    endtask

    task automatic t_io32();
        close_all();
        io_base_reg = 8'h21; io_limit_reg = 8'h21;
        io_base_up = 16'h0001; io_limit_up = 16'h0001; cmd_io_en = 1'b1;
        probe(64'h0001_2800, 1'b1, 1'b1, W_IO,   "R3");
        probe(64'h0000_2800, 1'b1, 1'b0, W_NONE, "R3");
        probe(64'h0001_2FFF, 1'b1, 1'b1, W_IO,   "R3");
    endtask

    task automatic t_mem();
        close_all();
        mem_base_reg = 16'h1230; mem_limit_reg = 16'h1240; cmd_mem_en = 1'b1;
        probe(64'h1230_0000, 1'b0, 1'b1, W_MEM,  "R10");
        probe(64'h124F_FFFF, 1'b0, 1'b1, W_MEM,  "R4");
        probe(64'h1250_0000, 1'b0, 1'b0, W_NONE, "R4");
        probe(64'h122F_FFFF, 1'b0, 1'b0, W_NONE, "R4");
        probe(64'h1_1230_0000, 1'b0, 1'b0, W_NONE, "R4");
        probe(64'h1230_0000, 1'b1, 1'b0, W_NONE, "R6");
        cmd_mem_en = 1'b0;
        probe(64'h1230_0000, 1'b0, 1'b0, W_NONE, "R6");
    endtask

    task automatic t_pref();
        close_all();
        cmd_mem_en = 1'b1;
        pf_base_reg = 16'h8001; pf_limit_reg = 16'h8001;
        pf_base_up = 32'h2; pf_limit_up = 32'h2;
        probe(64'h2_8000_0010, 1'b0, 1'b1, W_PREF, "R5");
        probe(64'h2_800F_FFFF, 1'b0, 1'b1, W_PREF, "R5");
        probe(64'h0_8000_0010, 1'b0, 1'b0, W_NONE, "R5");
        // Narrow type: upper registers are ignored.
        pf_base_reg = 16'hA000; pf_limit_reg = 16'hA000;
        pf_base_up = 32'h5; pf_limit_up = 32'h5;
        probe(64'h0_A000_0000, 1'b0, 1'b1, W_PREF, "R5");
        probe(64'h5_A000_0000, 1'b0, 1'b0, W_NONE, "R5");
        // Overlap with memory window reports prefetchable.
        mem_base_reg = 16'hA000; mem_limit_reg = 16'hA000;
        probe(64'h0_A008_0000, 1'b0, 1'b1, W_PREF, "R9");
    endtask

    task automatic t_empty();
        close_all();
        cmd_mem_en = 1'b1;
        mem_base_reg = 16'h2000; mem_limit_reg = 16'h1000;
        probe(64'h2000_0000, 1'b0, 1'b0, W_NONE, "R7");
        probe(64'h1000_0000, 1'b0, 1'b0, W_NONE, "R7");
        probe(64'h1800_0000, 1'b0, 1'b0, W_NONE, "R7");
    endtask

    task automatic t_vga();
        close_all();
        vga_en = 1'b1;
        probe(64'hA0000, 1'b0, 1'b1, W_VGA,  "R8");
        probe(64'hBFFFF, 1'b0, 1'b1, W_VGA,  "R8");
        probe(64'hC0000, 1'b0, 1'b0, W_NONE, "R8");
        probe(64'h9FFFF, 1'b0, 1'b0, W_NONE, "R8");
        probe(64'h3B0,   1'b1, 1'b1, W_VGA,  "R8");
        probe(64'h3BB,   1'b1, 1'b1, W_VGA,  "R8");
        probe(64'h3BC,   1'b1, 1'b0, W_NONE, "R8");
        probe(64'h3C0,   1'b1, 1'b1, W_VGA,  "R8");
        probe(64'h3DF,   1'b1, 1'b1, W_VGA,  "R8");
        probe(64'h3E0,   1'b1, 1'b0, W_NONE, "R8");
        probe(64'h3C0,   1'b0, 1'b0, W_NONE, "R8");
        // Memory window covering the legacy range takes priority.
        cmd_mem_en = 1'b1; mem_base_reg = 16'h0000; mem_limit_reg = 16'h0000;
        probe(64'hA0000, 1'b0, 1'b1, W_MEM, "R9");
        // I/O window covering a legacy I/O range takes priority.
        cmd_io_en = 1'b1; io_base_reg = 8'h00; io_limit_reg = 8'h00;
        probe(64'h3C4, 1'b1, 1'b1, W_IO, "R9");
        vga_en = 1'b0; cmd_mem_en = 1'b0;
        probe(64'hA0000, 1'b0, 1'b0, W_NONE, "R8");
        // R11: forward flag tracks a non-zero window code (checked in probes).
        probe(64'h3C4, 1'b1, 1'b1, W_IO, "R11");
    endtask

    initial begin
        #(20ns * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        close_all();
        t_reset();
        t_io16();
        t_io32();
        t_mem();
        t_pref();
        t_empty();
        t_vga();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule